// File: doc/BRIEF.md
# Glitch-Free Clock Source Selector

This block drives a set of independent base clocks, one per stage. Each base clock can be moved from one input clock to another while it runs, and the output never shows a runt pulse or a shortened phase. Every stage has two source slots, side A and side B. Each slot holds an input code that picks one of the shared input clocks. A two-bit control field says which side should drive the stage output. A two-bit status field says which side actually drives it.

To move a stage to a new input, software first reads the status and loads the input code into the slot that is idle. It then writes the control field with the status bits inverted. The stage first turns the old side off, synchronised to the old clock and timed to its low phase. Only then does it turn the new side on, at a low phase of the new clock. The status follows the real state of the two side gates and returns to the register clock through a synchroniser, so it settles several cycles after the control write.

A typical use is to park a domain on the crystal clock (code 1) while a PLL is retuned, and to move it back to the PLL output (code 9) once the PLL has locked.

Top module: `clk_source_switch`

## Requirements
- R1: After reset every stage holds control 01, status 01, side A code 1 (fast crystal) and side B code 0. The stage output then runs at the frequency of input clock 1.
- R2: The register address is {stage index, field}, with field 0 = control, 1 = side A code, 2 = side B code, 3 = status (read only). Reads return the value zero-extended. Addresses of stages beyond the last one read as 0 and ignore writes.
- R3: A code write to a side is stored only when that side is idle, meaning its control bit and its status bit are both 0. A code write to a side in use is ignored.
- R4: A control write is accepted only if exactly one of its two low bits is set (bit 0 = side A, bit 1 = side B). Values 00 and 11 are ignored.
- R5: A control write that arrives while a handover is still in progress (status differs from control) is ignored.
- R6: Status bit 0 is 1 while side A gates the output and bit 1 is 1 while side B gates it. On the cycle after a control write the status still shows the old value. It later settles to the new control value.
- R7: After a handover completes, the stage output runs at the frequency of the input clock named by the code of the newly active side.
- R8: A handover is break-before-make: the two sides never gate the output at the same time, and no output high or low phase is shorter than the shorter half period of the two input clocks involved.
- R9: A handover in one stage does not disturb the output of any other stage.
- R10: A code write with a value not below the number of input clocks is ignored.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Register clock |
| rst | input | 1 | Synchronous active-high reset; held while the input clocks run |
| src_clks | input | NSRC | Shared input clocks, indexed by code |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | ADDR_W | {stage index, field} |
| reg_wdata | input | DATA_W | Write data |
| reg_rdata | output | DATA_W | Combinational read data for reg_addr |
| stage_clks | output | NSTAGE | One switched base clock per stage |

## Verification
The hardest case to reach is a second control write that lands inside the handover window. The window is only a few tens of nanoseconds wide, and the status has not moved yet when the write arrives. The bench issues the second control write on the very next register cycle after the first, so the write is sure to fall inside the window. It also reads the status at that moment, which proves the lag. It then watches every output edge across a full round trip, from the crystal input to a slow input and back to a mid-speed input, and checks for any phase shorter than the fastest half period involved.

// File: rtl/clksw_pkg.sv
package clksw_pkg;

    // Field index within one stage's address window
    typedef enum logic [1:0] {
        FLD_CTRL  = 2'd0,
        FLD_SEL_A = 2'd1,
        FLD_SEL_B = 2'd2,
        FLD_STAT  = 2'd3
    } field_e;

    localparam logic [1:0] SIDE_A_ONLY = 2'b01;
    localparam logic [1:0] SIDE_B_ONLY = 2'b10;

    localparam int FAST_XTAL_CODE = 1;
    localparam int MAIN_PLL_CODE  = 9;

    // Decoded write strobes for one stage
    typedef struct packed {
        logic ctrl_we;
        logic sel_a_we;
        logic sel_b_we;
    } stage_we_t;

    // A control word must name exactly one side
    function automatic logic ctrl_word_ok(input logic [1:0] v);
        return v[0] ^ v[1];
    endfunction

    function automatic stage_we_t decode_field(input logic wr, input logic [1:0] fld);
        stage_we_t w;
        w.ctrl_we  = wr && (fld == FLD_CTRL);
        w.sel_a_we = wr && (fld == FLD_SEL_A);
        w.sel_b_we = wr && (fld == FLD_SEL_B);
        return w;
    endfunction

endpackage

// File: rtl/clksw_side.sv
// One side of a stage: picks an input clock by code and gates it.
// The enable passes through two flops on rising edges of the picked clock,
// then a final flop on its falling edge, so the gate only moves while the
// clock is low.
module clksw_side #(
    parameter int   NSRC   = 10,
    parameter int   SEL_W  = 4,
    parameter logic RST_ON = 1'b0
) (
    input  logic             rst,
    input  logic [NSRC-1:0]  src_clks,
    input  logic [SEL_W-1:0] sel,
    input  logic             req,
    input  logic             other_on,
    output logic             on,
    output logic             gated
);

    logic sclk;
    logic sync_1, sync_2;

    // sel only changes while this side is off (see stage write rules)
    assign sclk = src_clks[sel];

    always_ff @(posedge sclk) begin
        if (rst) begin
            sync_1 <= RST_ON;
            sync_2 <= RST_ON;
        end else begin
            sync_1 <= req & ~other_on;
            sync_2 <= sync_1;
        end
    end

    always_ff @(negedge sclk) begin
        if (rst) on <= RST_ON;
        else     on <= sync_2;
    end

    assign gated = sclk & on;

endmodule

// File: rtl/clksw_stage.sv
// One selection stage: two code slots, control, status and two gated sides.
module clksw_stage
    import clksw_pkg::*;
#(
    parameter int NSRC   = 10,
    parameter int SEL_W  = 4,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_clks,
    input  logic              wr,
    input  logic [1:0]        field,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output logic              clk_out
);

    logic [1:0]       ctrl;
    logic [SEL_W-1:0] sel_a, sel_b;
    logic [1:0]       stat_meta, stat;
    logic             on_a, on_b, gated_a, gated_b;
    logic             busy_a, busy_b, pending, code_ok;
    stage_we_t        we;

    assign we      = decode_field(wr, field);
    assign busy_a  = ctrl[0] | stat[0];
    assign busy_b  = ctrl[1] | stat[1];
    assign pending = (ctrl != stat);
    assign code_ok = (wdata < DATA_W'(NSRC));

    // Register state
    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl  <= SIDE_A_ONLY;
            sel_a <= SEL_W'(FAST_XTAL_CODE);
            sel_b <= '0;
        end else begin
            if (we.ctrl_we && ctrl_word_ok(wdata[1:0]) && !pending)
                ctrl <= wdata[1:0];
            if (we.sel_a_we && !busy_a && code_ok)
                sel_a <= wdata[SEL_W-1:0];
            if (we.sel_b_we && !busy_b && code_ok)
                sel_b <= wdata[SEL_W-1:0];
        end
    end

    // Side gates: each waits for the other to be off before enabling
    clksw_side #(.NSRC(NSRC), .SEL_W(SEL_W), .RST_ON(1'b1)) u_side_a (
        .rst      (rst),
        .src_clks (src_clks),
        .sel      (sel_a),
        .req      (ctrl[0]),
        .other_on (on_b),
        .on       (on_a),
        .gated    (gated_a)
    );

    clksw_side #(.NSRC(NSRC), .SEL_W(SEL_W), .RST_ON(1'b0)) u_side_b (
        .rst      (rst),
        .src_clks (src_clks),
        .sel      (sel_b),
        .req      (ctrl[1]),
        .other_on (on_a),
        .on       (on_b),
        .gated    (gated_b)
    );

    assign clk_out = gated_a | gated_b;

    // Actual gate state back into the register domain
    always_ff @(posedge clk) begin
        if (rst) begin
            stat_meta <= SIDE_A_ONLY;
            stat      <= SIDE_A_ONLY;
        end else begin
            stat_meta <= {on_b, on_a};
            stat      <= stat_meta;
        end
    end

    always_comb begin
        rdata = '0;
        unique case (field_e'(field))
            FLD_CTRL:  rdata = {{(DATA_W-2){1'b0}}, ctrl};
            FLD_SEL_A: rdata = {{(DATA_W-SEL_W){1'b0}}, sel_a};
            FLD_SEL_B: rdata = {{(DATA_W-SEL_W){1'b0}}, sel_b};
            FLD_STAT:  rdata = {{(DATA_W-2){1'b0}}, stat};
            default:   rdata = '0;
        endcase
    end

    // Checks next to the logic they guard
    AST_CTRL_ONE_SIDE: assert property (@(posedge clk) disable iff (rst)
        $countones(ctrl) == 1);  // R4
    AST_CTRL_HELD_PENDING: assert property (@(posedge clk) disable iff (rst)
        $past(stat != ctrl) |-> $stable(ctrl));  // R5
    AST_STAT_MOVES_PENDING: assert property (@(posedge clk) disable iff (rst)
        (stat != $past(stat)) |-> ($past(stat) != $past(ctrl)));  // R6
    AST_SEL_A_HELD: assert property (@(posedge clk) disable iff (rst)
        $past(busy_a) |-> $stable(sel_a));  // R3
    AST_SEL_B_HELD: assert property (@(posedge clk) disable iff (rst)
        $past(busy_b) |-> $stable(sel_b));  // R3
    AST_NO_OVERLAP: assert property (@(posedge clk) disable iff (rst)
        !(on_a && on_b));  // R8
    AST_SEL_RANGE: assert property (@(posedge clk) disable iff (rst)
        (sel_a < SEL_W'(NSRC)) && (sel_b < SEL_W'(NSRC)));  // R10

endmodule

// File: rtl/clk_source_switch.sv
// Array of independent clock selection stages behind one register port.
module clk_source_switch
    import clksw_pkg::*;
#(
    parameter int NSTAGE = 12,
    parameter int NSRC   = 10,
    parameter int DATA_W = 8,
    localparam int STAGE_W = $clog2(NSTAGE),
    localparam int ADDR_W  = STAGE_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [NSRC-1:0]   src_clks,
    input  logic              reg_wr,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [DATA_W-1:0] reg_wdata,
    output logic [DATA_W-1:0] reg_rdata,
    output logic [NSTAGE-1:0] stage_clks
);

    localparam int SEL_W = $clog2(NSRC);

    logic [STAGE_W-1:0] stage_idx;
    logic [1:0]         field;
    logic [DATA_W-1:0]  stage_rdata [NSTAGE];

    assign stage_idx = reg_addr[ADDR_W-1:2];
    assign field     = reg_addr[1:0];

    for (genvar g = 0; g < NSTAGE; g++) begin : g_stage
        logic hit;
        assign hit = reg_wr && (stage_idx == STAGE_W'(g));

        clksw_stage #(.NSRC(NSRC), .SEL_W(SEL_W), .DATA_W(DATA_W)) u_stage (
            .clk      (clk),
            .rst      (rst),
            .src_clks (src_clks),
            .wr       (hit),
            .field    (field),
            .wdata    (reg_wdata),
            .rdata    (stage_rdata[g]),
            .clk_out  (stage_clks[g])
        );
    end

    always_comb begin
        reg_rdata = '0;
        for (int i = 0; i < NSTAGE; i++)
            if (stage_idx == STAGE_W'(i))
                reg_rdata = stage_rdata[i];
    end

    AST_ADDR_IN_RANGE_RDATA: assert property (@(posedge clk) disable iff (rst)
        (int'(stage_idx) >= NSTAGE) |-> (reg_rdata == '0));  // R2

endmodule

// File: tb/clk_source_switch_test.sv
module clk_source_switch_test;

    localparam int CLK_PERIOD = 10;
    localparam int NSTAGE  = 12;
    localparam int NSRC    = 10;
    localparam int DATA_W  = 8;
    localparam int STAGE_W = $clog2(NSTAGE);
    localparam int ADDR_W  = STAGE_W + 2;

    logic              clk = 0;
    logic              rst = 1;
    logic [NSRC-1:0]   src_clks;
    logic              reg_wr = 0;
    logic [ADDR_W-1:0] reg_addr = '0;
    logic [DATA_W-1:0] reg_wdata = '0;
    logic [DATA_W-1:0] reg_rdata;
    logic [NSTAGE-1:0] stage_clks;

    int errors = 0;
    int checks = 0;
    bit done = 0;

    clk_source_switch #(.NSTAGE(NSTAGE), .NSRC(NSRC), .DATA_W(DATA_W)) uut (
        .clk(clk), .rst(rst), .src_clks(src_clks), .reg_wr(reg_wr),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .stage_clks(stage_clks)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    // Input clock i has half period 3+i
    for (genvar g = 0; g < NSRC; g++) begin : g_src
        initial begin
            src_clks[g] = 1'b0;
            forever #(3 + g) src_clks[g] = ~src_clks[g];
        end
    end

    // Phase-width monitor on stage 0
    bit      mon_arm = 0;
    bit      mon_first = 1;
    realtime mon_last = 0;
    realtime mon_min = 1.0e9;
    always @(stage_clks[0]) begin
        if (mon_arm) begin
            if (mon_first) mon_first = 0;
            else if ($realtime - mon_last < mon_min) mon_min = $realtime - mon_last;
            mon_last = $realtime;
        end
    end

    function automatic logic [ADDR_W-1:0] adr(input int stage, input int fld);
        return {STAGE_W'(stage), 2'(fld)};
    endfunction

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic reg_write(input logic [ADDR_W-1:0] a, input int d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = DATA_W'(d);
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic reg_read(input logic [ADDR_W-1:0] a, output int d);
        reg_addr = a;
        #1;
        d = int'(reg_rdata);
    endtask

    task automatic expect_reg(input int stage, input int fld, input int exp, input string req);
        int v;
        reg_read(adr(stage, fld), v);
        check(v == exp, req, v, exp);
    endtask

    // Wait for status to settle; returns whether 11 was ever seen
    task automatic wait_status(input int stage, input int exp, input string req, output bit saw_both);
        int v = -1;
        saw_both = 0;
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            reg_read(adr(stage, 3), v);
            if (v == 3) saw_both = 1;
            if (v == exp) break;
        end
        check(v == exp, req, v, exp);
    endtask

    // Output period must equal the period of input k
    task automatic expect_freq(input int stage, input int k, input string req);
        realtime t0, t1;
        for (int n = 0; n < 3; n++) begin
            @(posedge stage_clks[stage]); t0 = $realtime;
            @(posedge stage_clks[stage]); t1 = $realtime;
            check(int'(t1 - t0) == 2 * (3 + k), req, int'(t1 - t0), 2 * (3 + k));
        end
    endtask

    task automatic t_reset;
        expect_reg(0, 0, 1, "R1 ctrl");
        expect_reg(0, 3, 1, "R1 status");
        expect_reg(0, 1, 1, "R1 side A code");
        expect_reg(0, 2, 0, "R1 side B code");
        expect_reg(11, 3, 1, "R1 last stage status");
        expect_freq(0, 1, "R1 output on crystal");
    endtask

    task automatic t_code_writes;
        reg_write(adr(0, 2), 9);
        expect_reg(0, 2, 9, "R3 idle side B stored");
        reg_write(adr(0, 1), 5);
        expect_reg(0, 1, 1, "R3 active side A write ignored");
        reg_write(adr(0, 2), 12);
        expect_reg(0, 2, 9, "R10 out-of-range code ignored");
        reg_write(adr(0, 2), 10);
        expect_reg(0, 2, 9, "R10 code equal to NSRC ignored");
    endtask

    task automatic t_bad_ctrl;
        reg_write(adr(0, 0), 3);
        expect_reg(0, 0, 1, "R4 ctrl 11 ignored");
        reg_write(adr(0, 0), 0);
        expect_reg(0, 0, 1, "R4 ctrl 00 ignored");
        expect_reg(0, 3, 1, "R4 status unchanged");
        expect_freq(0, 1, "R4 output still crystal");
    endtask

    task automatic t_handover;
        bit both;
        mon_first = 1; mon_min = 1.0e9; mon_arm = 1;
        reg_write(adr(0, 0), 2);
        expect_reg(0, 3, 1, "R6 status lags write");
        expect_reg(0, 0, 2, "R4 ctrl 10 accepted");
        reg_write(adr(0, 0), 1);
        expect_reg(0, 0, 2, "R5 write during handover ignored");
        wait_status(0, 2, "R6 status settles to B", both);
        check(!both, "R8 both sides seen", int'(both), 0);
        expect_freq(0, 9, "R7 output on code 9");
        expect_freq(1, 1, "R9 stage 1 undisturbed");
        reg_write(adr(0, 1), 3);
        expect_reg(0, 1, 3, "R3 side A now idle, stored");
        reg_write(adr(0, 2), 4);
        expect_reg(0, 2, 9, "R3 active side B write ignored");
        reg_write(adr(0, 0), 1);
        wait_status(0, 1, "R6 status settles to A", both);
        check(!both, "R8 both sides seen on return", int'(both), 0);
        expect_freq(0, 3, "R7 output on code 3");
        mon_arm = 0;
        check(mon_min >= 4.0, "R8 minimum phase", int'(mon_min), 4);
    endtask

    task automatic t_bad_stage;
        int v;
        reg_write(adr(13, 2), 5);
        reg_read(adr(13, 2), v);
        check(v == 0, "R2 unused stage reads zero", v, 0);
        expect_reg(1, 2, 0, "R2 no alias into stage 1");
        expect_reg(5, 2, 0, "R2 no alias into stage 5");
    endtask

    task automatic finish_run;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    endtask

    initial begin
        repeat (20) @(negedge clk);
        rst = 0;
        repeat (4) @(negedge clk);
        t_reset;
        t_code_writes;
        t_bad_ctrl;
        t_handover;
        t_bad_stage;
        done = 1;
        finish_run;
    end

    initial begin
        #(CLK_PERIOD * 150000);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=%0d expected=%0d", 0, 1);
            finish_run;
        end
    end

endmodule